// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing front end of a small byte-addressed serial memory. It runs on a fast system clock and oversamples the two bus wires through synchronizers. It finds START and STOP conditions and shifts bytes in, most significant bit first. It drives the open-drain data wire low to acknowledge and to send read data. The first byte of a command is a control byte carrying a device code, three chip-select bits and a direction bit. In a write, the next byte loads the address pointer and every later byte goes to an external write path with its address. In a read, bytes are fetched from an external memory port at the pointer and shifted out.

The memory array, the page buffer and the write-cycle timer sit outside. The timer reports through `busy_i`, and while it is high the engine acknowledges nothing. The engine acknowledges write data no matter whether the array is write-protected, because the external write path discards protected writes.

States: `ST_IDLE`, `ST_CTRL` (control byte in), `ST_CTRL_ACK`, `ST_WADDR` (word address in), `ST_WADDR_ACK`, `ST_WDATA` (write data in), `ST_WDATA_ACK`, `ST_RDATA` (read byte out), `ST_RACK` (master acknowledge slot) and `ST_IGNORE` (silent until the next bus condition). Transitions:
- START in any state goes to `ST_CTRL`. STOP in any state goes to `ST_IDLE`.
- A complete byte in `ST_CTRL`, `ST_WADDR` or `ST_WDATA` goes to the matching acknowledge state when it is accepted, or to `ST_IGNORE` when it is refused.
- On the falling clock edge, `ST_CTRL_ACK` goes to `ST_RDATA` for a read or to `ST_WADDR` for a write.
- On the falling clock edge, `ST_WADDR_ACK` and `ST_WDATA_ACK` go to `ST_WDATA`.
- After eight bits, `ST_RDATA` goes to `ST_RACK`.
- On the falling clock edge, `ST_RACK` goes back to `ST_RDATA` when the master acknowledged, or to `ST_IGNORE` when it did not.

Top module: `eeprom_twi_slave`

## Requirements
- R1: A falling data line while the clock is high is a START. From any state, a START drops the transfer in progress and restarts control-byte reception. A rising data line while the clock is high is a STOP, and it returns the engine to idle.
- R2: The control byte is accepted only when bits 7:4 equal the device code 1010 and bits 3:1 equal `strap_i[2:0]`. Bit 0 selects a read (1) or a write (0). To acknowledge, the engine holds the data line low through the high phase of the ninth clock. A control byte that fails the match is not acknowledged.
- R3: While `busy_i` is high at the end of a byte, that byte is not acknowledged, whether it is a control, address or data byte. A refused data byte raises no `wr_valid_o`.
- R4: In a write, the second byte loads the pointer. Every later byte is acknowledged, and it produces a one-cycle `wr_valid_o` with `wr_addr_o` set to the pointer and `wr_data_o` set to the byte.
- R5: After each write data byte, only the low PAGE_W pointer bits increment, wrapping inside the page. The upper bits hold.
- R6: A STOP after at least one accepted write data byte gives exactly one `wr_commit_o` pulse. A STOP with no accepted data byte gives none.
- R7: Read bytes come from `rd_data_i` at `rd_addr_o` and are sent most significant bit first. After each byte the master acknowledges, the full pointer increments and wraps from all-ones to zero.
- R8: When the master does not acknowledge a read byte, the engine leaves the data line released until the next START or STOP.
- R9: The engine starts pulling the data line low only while the clock is low, RELEASE_DLY system clocks after a registered request taken at the clock's falling edge.
- R10: After reset, the data line is released and `wr_valid_o` and `wr_commit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_drive_low_o | output | 1 | 1 pulls the data wire low; 0 releases it |
| strap_i | input | 3 | Chip-select strap levels |
| busy_i | input | 1 | Internal write cycle in progress |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr_o | output | ADDR_W | Address of the write byte |
| wr_data_o | output | 8 | Write byte value |
| wr_commit_o | output | 1 | One-cycle strobe that starts the write cycle at STOP |
| rd_addr_o | output | ADDR_W | Read address (current pointer) |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o` |

## Verification
The bench uses the default parameters: an 8-bit pointer, 16-byte pages, two synchronizer stages and a release delay of four clocks. With 16-byte pages, a three-byte write starting at 0x3E crosses a page edge and must wrap back to 0x30. With an 8-bit pointer, a sequential read starting at 0xFE reaches the full wrap from 0xFF to 0x00 in three bytes. The short release delay leaves a wide margin inside the bench's 12-clock low quarter, so a late change on the data line would land in the clock-high window that the monitor watches.

// File: rtl/eeprom_twi_pkg.sv
package eeprom_twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_o      = scl_ff[STAGES-1];
    assign sda_o      = sda_ff[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_q;
    assign scl_fall_o = ~scl_o & scl_q;
    assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/twi_sda_driver.sv
module twi_sda_driver #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic val_i,
    input  logic release_now_i,
    output logic low_o
);

    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_o   <= 1'b0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (release_now_i) begin
            low_o   <= 1'b0;
            armed_q <= 1'b0;
        end else if (req_i) begin
            pend_q  <= val_i;
            armed_q <= 1'b1;
            cnt_q   <= CW'(DLY);
        end else if (armed_q) begin
            if (cnt_q <= CW'(1)) begin
                low_o   <= pend_q;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    AST_DRV_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !release_now_i) |=> $stable(low_o)); // R9

endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
    import eeprom_twi_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_W      = 4,
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         SYNC_STAGES = 2,
    parameter int         RELEASE_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low_o,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_commit_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
    logic drv_req, drv_val;

    twi_state_e        state_q, state_d;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              rw_q, mst_ack_q, wr_seen_q;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(ev_start), .stop_o(ev_stop)
    );

    twi_sda_driver #(.DLY(RELEASE_DLY)) u_drv (
        .clk(clk), .rst_n(rst_n), .req_i(drv_req), .val_i(drv_val),
        .release_now_i(ev_start | ev_stop), .low_o(sda_drive_low_o)
    );

    wire byte_end   = scl_fall && (bitcnt_q == BYTE_BITS);
    wire ctrl_match = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_i);
    wire rx_state   = (state_q == ST_CTRL) || (state_q == ST_WADDR) || (state_q == ST_WDATA);

    assign rd_addr_o = ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ev_start) begin
            state_d = ST_CTRL;
        end else if (ev_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_CTRL:      if (byte_end) state_d = (ctrl_match && !busy_i) ? ST_CTRL_ACK : ST_IGNORE;
                ST_WADDR:     if (byte_end) state_d = busy_i ? ST_IGNORE : ST_WADDR_ACK;
                ST_WDATA:     if (byte_end) state_d = busy_i ? ST_IGNORE : ST_WDATA_ACK;
                ST_CTRL_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (byte_end) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mst_ack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q    <= '0;
            shreg_q     <= '0;
            ptr_q       <= '0;
            rw_q        <= 1'b0;
            mst_ack_q   <= 1'b0;
            wr_seen_q   <= 1'b0;
            wr_valid_o  <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            wr_commit_o <= 1'b0;
            drv_req     <= 1'b0;
            drv_val     <= 1'b0;
        end else begin
            wr_valid_o  <= 1'b0;
            wr_commit_o <= 1'b0;
            drv_req     <= 1'b0;
            if (ev_start) begin
                bitcnt_q  <= '0;
                wr_seen_q <= 1'b0;
            end else if (ev_stop) begin
                wr_commit_o <= wr_seen_q;
                wr_seen_q   <= 1'b0;
                bitcnt_q    <= '0;
            end else begin
                if (scl_rise) begin
                    if (rx_state) begin
                        shreg_q  <= {shreg_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (state_q == ST_RDATA) begin
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (state_q == ST_RACK) begin
                        mst_ack_q <= !sda_s;
                        if (!sda_s) ptr_q <= ptr_q + ADDR_W'(1);
                    end
                end
                if (scl_fall) begin
                    unique case (state_q)
                        ST_CTRL: if (bitcnt_q == BYTE_BITS) begin
                            rw_q <= shreg_q[0];
                            if (ctrl_match && !busy_i) begin
                                drv_req <= 1'b1; drv_val <= 1'b1;
                            end
                        end
                        ST_WADDR: if (bitcnt_q == BYTE_BITS && !busy_i) begin
                            ptr_q   <= shreg_q[ADDR_W-1:0];
                            drv_req <= 1'b1; drv_val <= 1'b1;
                        end
                        ST_WDATA: if (bitcnt_q == BYTE_BITS && !busy_i) begin
                            wr_valid_o <= 1'b1;
                            wr_addr_o  <= ptr_q;
                            wr_data_o  <= shreg_q;
                            wr_seen_q  <= 1'b1;
                            ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                            drv_req <= 1'b1; drv_val <= 1'b1;
                        end
                        ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                            bitcnt_q <= '0;
                            drv_req  <= 1'b1;
                            if (state_q == ST_CTRL_ACK && rw_q) begin
                                shreg_q <= rd_data_i;
                                drv_val <= !rd_data_i[7];
                            end else begin
                                drv_val <= 1'b0;
                            end
                        end
                        ST_RDATA: begin
                            drv_req <= 1'b1;
                            if (bitcnt_q == BYTE_BITS) begin
                                bitcnt_q <= '0;
                                drv_val  <= 1'b0;
                            end else begin
                                shreg_q <= {shreg_q[6:0], 1'b0};
                                drv_val <= !shreg_q[6];
                            end
                        end
                        ST_RACK: begin
                            bitcnt_q <= '0;
                            if (mst_ack_q) begin
                                shreg_q <= rd_data_i;
                                drv_req <= 1'b1;
                                drv_val <= !rd_data_i[7];
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    wire in_ack = (state_q == ST_CTRL_ACK) || (state_q == ST_WADDR_ACK) || (state_q == ST_WDATA_ACK);
    wire in_wr  = (state_q == ST_WDATA) || (state_q == ST_WDATA_ACK);

    AST_CTRL_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_CTRL_ACK) |-> ($past(shreg_q[7:4]) == DEV_CODE && $past(shreg_q[3:1]) == $past(strap_i))); // R2
    AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && !$past(in_ack)) |-> !$past(busy_i)); // R3
    AST_WR_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (state_q == ST_WDATA_ACK)); // R4
    AST_PAGE_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr && $past(in_wr)) |-> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]))); // R5
    AST_COMMIT_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> (state_q == ST_IDLE)); // R6
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o); // R6
    AST_SILENT_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_drive_low_o); // R8
    AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_s); // R9

endmodule

// File: tb/eeprom_twi_slave_bench.sv
module eeprom_twi_slave_bench;

    localparam int Q = 12;
    localparam int H = 25;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy  = 1'b0;
    logic [2:0] strap = 3'b101;

    logic       sda_low, wr_valid, wr_commit;
    logic [7:0] wr_addr, wr_data, rd_addr;
    logic [7:0] mem [256];
    wire        sda_bus = sda_m & ~sda_low;
    wire  [7:0] rd_data = mem[rd_addr];

    eeprom_twi_slave u_eeprom_twi_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low_o(sda_low), .strap_i(strap), .busy_i(busy),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    int n_chk = 0, n_bad = 0;
    int n_wr = 0, n_commit = 0, r9_bad = 0;
    logic [7:0] log_a [16];
    logic [7:0] log_d [16];
    logic prev_low = 1'b0;

    always @(posedge clk) begin
        if (wr_valid) begin
            if (n_wr < 16) begin log_a[n_wr] = wr_addr; log_d[n_wr] = wr_data; end
            n_wr++;
        end
        if (wr_commit) n_commit++;
    end

    always @(negedge clk) begin
        if (sda_low && !prev_low && scl_m) r9_bad++;
        prev_low = sda_low;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; wt(Q); scl_m = 1'b1; wt(H / 2); s = sda_bus; wt(H - H / 2); scl_m = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, ack_n);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
        clk_bit(!mack, s);
    endtask

    task automatic t_reset();
        check("R10 data line released", 32'(sda_low), 32'd0);
        check("R10 no write strobe", 32'(wr_valid), 32'd0);
        check("R10 no commit", 32'(wr_commit), 32'd0);
    endtask

    task automatic t_ctrl_filter();
        logic a; int c0;
        c0 = n_commit;
        bus_start(); send_byte(8'hBA, a); check("R2 wrong code refused", 32'(a), 32'd1); bus_stop();
        bus_start(); send_byte(8'hA8, a); check("R2 wrong strap refused", 32'(a), 32'd1); bus_stop();
        bus_start(); send_byte(8'hAA, a); check("R2 match acknowledged", 32'(a), 32'd0); bus_stop();
        wt(5);
        check("R6 no commit without data", 32'(n_commit - c0), 32'd0);
    endtask

    task automatic t_page_write();
        logic a; int c0, w0;
        logic [7:0] dat [3];
        dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
        c0 = n_commit; w0 = n_wr;
        bus_start();
        send_byte(8'hAA, a); check("R4 ctrl ack", 32'(a), 32'd0);
        send_byte(8'h3E, a); check("R4 address ack", 32'(a), 32'd0);
        for (int i = 0; i < 3; i++) begin
            send_byte(dat[i], a); check("R4 data ack", 32'(a), 32'd0);
        end
        bus_stop(); wt(5);
        check("R4 strobe count", 32'(n_wr - w0), 32'd3);
        check("R4 byte0 addr", 32'(log_a[w0]), 32'h3E);
        check("R4 byte0 data", 32'(log_d[w0]), 32'h11);
        check("R5 byte1 addr", 32'(log_a[w0 + 1]), 32'h3F);
        check("R4 byte1 data", 32'(log_d[w0 + 1]), 32'h22);
        check("R5 page wrap addr", 32'(log_a[w0 + 2]), 32'h30);
        check("R4 byte2 data", 32'(log_d[w0 + 2]), 32'h33);
        check("R6 one commit", 32'(n_commit - c0), 32'd1);
    endtask

    task automatic t_busy();
        logic a; int c0, w0;
        c0 = n_commit; w0 = n_wr;
        busy = 1'b1;
        bus_start(); send_byte(8'hAA, a); check("R3 ctrl refused while busy", 32'(a), 32'd1); bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h40, a); check("R3 address ack when idle", 32'(a), 32'd0);
        busy = 1'b1;
        send_byte(8'h55, a); check("R3 data refused while busy", 32'(a), 32'd1);
        bus_stop(); busy = 1'b0; wt(5);
        check("R3 no strobe for refused byte", 32'(n_wr - w0), 32'd0);
        check("R6 no commit for refused data", 32'(n_commit - c0), 32'd0);
    endtask

    task automatic t_seq_read();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'hFE, a);
        bus_start();
        send_byte(8'hAB, a); check("R2 read ctrl ack", 32'(a), 32'd0);
        recv_byte(d, 1'b1); check("R7 read byte FE", 32'(d), 32'(mem[8'hFE]));
        recv_byte(d, 1'b1); check("R7 read byte FF", 32'(d), 32'(mem[8'hFF]));
        recv_byte(d, 1'b0); check("R7 read wrap to 00", 32'(d), 32'(mem[8'h00]));
        recv_byte(d, 1'b0); check("R8 silent after master nack", 32'(d), 32'hFF);
        bus_stop();
    endtask

    task automatic t_abort();
        logic a, s; logic [7:0] d; int w0;
        w0 = n_wr;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h10, a);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
        bus_start();
        send_byte(8'hAB, a); check("R1 ctrl after restart ack", 32'(a), 32'd0);
        recv_byte(d, 1'b0); check("R1 read after aborted byte", 32'(d), 32'(mem[8'h10]));
        bus_stop(); wt(5);
        check("R1 aborted byte not written", 32'(n_wr - w0), 32'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        wt(4);
        t_reset();
        rst_n = 1'b1;
        wt(10);
        t_ctrl_filter();
        t_page_write();
        t_busy();
        t_seq_read();
        t_abort();
        check("R9 no pull-down during clock high", 32'(r9_bad), 32'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog expired actual=stalled expected=done");
        finish_run();
    end

endmodule